// File: doc/BRIEF.md
# Parallel NOR Flash Write and Read Controller

This block sits between a host and an asynchronous parallel NOR flash. The host hands it one request at a time over a valid/ready interface. A request is either a single-word read, a word program, a sector erase, a block erase or a whole-chip erase. Each modifying request becomes a fixed unlock preamble of bus writes and then one final command cycle. The controller drives chip-enable, write-enable and output-enable itself. It keeps the address steady before write-enable falls, and it keeps the data driven until write-enable has risen again.

After the last write of a modifying request, the controller reads the target location again and again until the flash reports that the operation has finished. It watches one of two status bits, chosen by a plain control pin. In data-polling mode it waits for bit 7 to show the true value. In toggle mode it waits for bit 6 to stop changing between two reads. A cycle counter bounds the polling, and if the flash is still busy when the counter runs out, the request ends in an error pulse.

Back-pressure rules:
- `req_ready` is high only while the controller is idle.
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- From that edge, `req_ready` stays low until the cycle after the one-cycle `done` or `err` pulse.
- A request held valid during that time is neither taken nor queued.

Top module: `nor_wr_ctrl`

## Requirements
- R1: While reset is held and after reset is released, `req_ready` is 1, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, and `fl_dq_oe`, `done` and `err` are 0.
- R2: A program request (`req_op`=1) issues exactly four bus writes, given as address/data: 5555h/00AAh, 2AAAh/0055h, 5555h/00A0h, then the request address with the request data.
- R3: Sector erase (`req_op`=2), block erase (3) and chip erase (4) each issue exactly six bus writes: 5555h/00AAh, 2AAAh/0055h, 5555h/0080h, 5555h/00AAh, 2AAAh/0055h, then a final cycle. The final cycle is the request address with 0030h for sector erase, the request address with 0050h for block erase, and 5555h with 0010h for chip erase.
- R4: During every bus cycle, the address does not change while `fl_we_n` is low. The data is driven and unchanged in the first cycle after `fl_we_n` rises. `fl_we_n` stays low for exactly PULSE_CYC clock cycles. `fl_ce_n` is low whenever `fl_we_n` or `fl_oe_n` is low. `fl_we_n` and `fl_oe_n` are never low together.
- R5: A read request (`req_op`=0) makes exactly one bus read at the request address and no writes. It then pulses `done`, and from that pulse `rd_data` holds the word the flash returned.
- R6: With `poll_toggle`=0, polling ends with `done` on the first status read whose bit 7 equals the programmed data bit 7 (program) or 1 (erase).
- R7: With `poll_toggle`=1, polling ends with `done` on the first status read whose bit 6 equals bit 6 of the read before it.
- R8: If polling has lasted TIMEOUT_CYC cycles without completing, the request ends with `err` after the poll read in progress, and `done` is not pulsed.
- R9: `req_ready` goes low in the cycle after a request is accepted and rises only in the cycle after the `done`/`err` pulse. A request held valid meanwhile causes no bus activity and no extra `done`.
- R10: A request with `req_op` 5, 6 or 7 produces an `err` pulse in the cycle after acceptance and no bus cycle.
- R11: `done` and `err` are never high together, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 3 | 0 read, 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| req_addr | input | AW | Word address of the request |
| req_data | input | DW | Word to program |
| poll_toggle | input | 1 | Completion method: 0 data polling on bit 7, 1 toggle check on bit 6 |
| done | output | 1 | One-cycle pulse: request finished |
| err | output | 1 | One-cycle pulse: timeout or unsupported request |
| rd_data | output | DW | Word returned by the last read request |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the data bus driver |
| fl_dq_in | input | DW | Data returned by the flash |

## Verification
The hardest case to reach from the ports is the polling timeout, together with the toggle mode's edge where the last busy read and the first settled read happen to agree. In a normal run the flash settles long before any limit. To cover these cases, the bench's flash model stays busy for a programmed number of status reads. Set high enough, that count makes the controller's cycle bound expire. Set to small values, it lands the busy-to-settled change on each read position. A second request is also held valid during a program operation, which shows that back-pressure really holds off a new request.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_PROG     = 3'd1,
    OP_ERS_SECT = 3'd2,
    OP_ERS_BLK  = 3'd3,
    OP_ERS_CHIP = 3'd4
  } nor_op_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SETUP, PH_ACT, PH_HOLD
  } bus_phase_e;

  typedef enum logic [2:0] {
    C_IDLE, C_WR_GO, C_WR_WAIT, C_PL_GO, C_PL_WAIT, C_RD_GO, C_RD_WAIT, C_REPORT
  } ctl_state_e;

  // Number of bus writes making up a modifying request (0 for others).
  function automatic logic [2:0] seq_len(logic [2:0] op);
    case (op)
      OP_PROG:                             seq_len = 3'd4;
      OP_ERS_SECT, OP_ERS_BLK, OP_ERS_CHIP: seq_len = 3'd6;
      default:                             seq_len = 3'd0;
    endcase
  endfunction

  // True when write step i carries the request address instead of an unlock address.
  function automatic logic seq_uses_req_addr(logic [2:0] op, logic [2:0] i);
    seq_uses_req_addr = ((op == OP_PROG) && (i == 3'd3)) ||
                        (((op == OP_ERS_SECT) || (op == OP_ERS_BLK)) && (i == 3'd5));
  endfunction

  // True when write step i carries the request data word.
  function automatic logic seq_uses_req_data(logic [2:0] op, logic [2:0] i);
    seq_uses_req_data = (op == OP_PROG) && (i == 3'd3);
  endfunction

  function automatic logic [15:0] seq_cmd_addr(logic [2:0] i);
    seq_cmd_addr = ((i == 3'd1) || (i == 3'd4)) ? 16'h2AAA : 16'h5555;
  endfunction

  function automatic logic [7:0] seq_cmd_data(logic [2:0] op, logic [2:0] i);
    case (i)
      3'd0, 3'd3: seq_cmd_data = 8'hAA;
      3'd1, 3'd4: seq_cmd_data = 8'h55;
      3'd2:       seq_cmd_data = (op == OP_PROG) ? 8'hA0 : 8'h80;
      default: begin
        case (op)
          OP_ERS_SECT: seq_cmd_data = 8'h30;
          OP_ERS_BLK:  seq_cmd_data = 8'h50;
          default:     seq_cmd_data = 8'h10;
        endcase
      end
    endcase
  endfunction

endpackage

// File: rtl/nor_bus_phy.sv
// One asynchronous bus cycle: setup with CE# low, an active phase with WE# or
// OE# low, then a hold phase before CE# is released. Counts must be >= 1.
module nor_bus_phy
  import nor_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 16,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in
);

  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);

  bus_phase_e     ph;
  logic [CW-1:0]  cnt;
  logic           wr_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rdata  <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph     <= PH_SETUP;
          cnt    <= CW'(SETUP_CYC - 1);
          wr_q   <= wr;
          addr_q <= addr;
          data_q <= wdata;
        end
        PH_SETUP: if (cnt == '0) begin
          ph  <= PH_ACT;
          cnt <= CW'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_ACT: if (cnt == '0) begin
          ph  <= PH_HOLD;
          cnt <= CW'(HOLD_CYC - 1);
          if (!wr_q) rdata <= fl_dq_in;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) ph <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign ack       = (ph == PH_HOLD) && (cnt == '0);
  assign fl_ce_n   = (ph == PH_IDLE);
  assign fl_we_n   = !((ph == PH_ACT) && wr_q);
  assign fl_oe_n   = !((ph == PH_ACT) && !wr_q);
  assign fl_addr   = addr_q;
  assign fl_dq_out = data_q;
  assign fl_dq_oe  = wr_q && (ph != PH_IDLE);

  // R4: the flash samples the address when WE# falls.
  a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_addr));
  // R4: data is still driven when WE# rises.
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (fl_dq_oe && $stable(fl_dq_out)));
  // R4: strobes only inside a selected cycle, never both at once.
  a_r4_ce_frames: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

endmodule

// File: rtl/nor_poll_timer.sv
// Counts cycles spent polling; saturates at LIMIT and reports expiry.
module nor_poll_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (cnt != TW'(LIMIT))  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == TW'(LIMIT));

  // R8: once expired, the bound stays expired until polling is abandoned.
  a_r8_sticky_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr) |=> expired);

endmodule

// File: rtl/nor_wr_ctrl.sv
module nor_wr_ctrl
  import nor_pkg::*;
#(
  parameter int AW          = 19,
  parameter int DW          = 16,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int HOLD_CYC    = 1,
  parameter int TIMEOUT_CYC = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          poll_toggle,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in
);

  ctl_state_e     st;
  logic [2:0]     op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic [2:0]     idx;
  logic           tmode_q;
  logic           tog_first;
  logic           tog_prev;
  logic           rep_err;
  logic [DW-1:0]  rd_q;

  logic           phy_start, phy_wr, phy_ack;
  logic [AW-1:0]  phy_addr;
  logic [DW-1:0]  phy_wdata, phy_rdata;
  logic           tmr_clr, tmr_expired;
  logic           poll_hit, exp_b7, op_known;

  assign op_known = (req_op <= OP_ERS_CHIP);

  assign phy_start = (st == C_WR_GO) || (st == C_PL_GO) || (st == C_RD_GO);
  assign phy_wr    = (st == C_WR_GO);
  assign phy_addr  = ((st == C_WR_GO) && !seq_uses_req_addr(op_q, idx)) ?
                     AW'(seq_cmd_addr(idx)) : addr_q;
  assign phy_wdata = seq_uses_req_data(op_q, idx) ? data_q : DW'(seq_cmd_data(op_q, idx));

  // Status evaluation on the word just read back.
  assign exp_b7   = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign poll_hit = tmode_q ? (!tog_first && (phy_rdata[6] == tog_prev))
                            : (phy_rdata[7] == exp_b7);

  assign tmr_clr = !((st == C_PL_GO) || (st == C_PL_WAIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= C_IDLE;
      op_q      <= OP_READ;
      addr_q    <= '0;
      data_q    <= '0;
      idx       <= '0;
      tmode_q   <= 1'b0;
      tog_first <= 1'b1;
      tog_prev  <= 1'b0;
      rep_err   <= 1'b0;
      rd_q      <= '0;
    end else begin
      case (st)
        C_IDLE: if (req_valid) begin
          op_q    <= req_op;
          addr_q  <= req_addr;
          data_q  <= req_data;
          tmode_q <= poll_toggle;
          idx     <= '0;
          rep_err <= !op_known;
          if (!op_known)               st <= C_REPORT;
          else if (req_op == OP_READ)  st <= C_RD_GO;
          else                         st <= C_WR_GO;
        end
        C_WR_GO: st <= C_WR_WAIT;
        C_WR_WAIT: if (phy_ack) begin
          if (idx + 3'd1 == seq_len(op_q)) begin
            st        <= C_PL_GO;
            tog_first <= 1'b1;
          end else begin
            idx <= idx + 3'd1;
            st  <= C_WR_GO;
          end
        end
        C_PL_GO: st <= C_PL_WAIT;
        C_PL_WAIT: if (phy_ack) begin
          tog_first <= 1'b0;
          tog_prev  <= phy_rdata[6];
          if (poll_hit) begin
            rep_err <= 1'b0;
            st      <= C_REPORT;
          end else if (tmr_expired) begin
            rep_err <= 1'b1;
            st      <= C_REPORT;
          end else st <= C_PL_GO;
        end
        C_RD_GO: st <= C_RD_WAIT;
        C_RD_WAIT: if (phy_ack) begin
          rd_q <= phy_rdata;
          st   <= C_REPORT;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  assign req_ready = (st == C_IDLE);
  assign done      = (st == C_REPORT) && !rep_err;
  assign err       = (st == C_REPORT) && rep_err;
  assign rd_data   = rd_q;

  nor_bus_phy #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_phy (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (phy_start),
    .wr        (phy_wr),
    .addr      (phy_addr),
    .wdata     (phy_wdata),
    .ack       (phy_ack),
    .rdata     (phy_rdata),
    .fl_ce_n   (fl_ce_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_dq_in  (fl_dq_in)
  );

  nor_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .expired (tmr_expired)
  );

  // R9: no second acceptance while a request is in flight.
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R9, R11: a completion pulse lasts one cycle and reopens the interface.
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> (!done && !err && req_ready));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R10: unsupported codes are rejected at once and never reach the bus.
  a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_op > 3'd4)) |=> (err && fl_ce_n));
  // R1: the bus is parked while idle.
  a_r1_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_we_n && fl_oe_n && !fl_dq_oe));

endmodule

// File: tb/test_nor_wr_ctrl.sv
`timescale 1ns/1ps
module test_nor_wr_ctrl;

  localparam int AW = 19, DW = 16;
  localparam int SETUP = 2, PULSE = 3, HOLD = 1, TMO = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, poll_toggle = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, err;
  logic [DW-1:0] rd_data;
  logic fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out, fl_dq_in;

  always #2 clk = ~clk;

  nor_wr_ctrl #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
                .HOLD_CYC(HOLD), .TIMEOUT_CYC(TMO)) i_nor_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .poll_toggle(poll_toggle), .done(done), .err(err), .rd_data(rd_data),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [15:0] mem [16];
  logic [18:0] log_a [8];
  logic [15:0] log_d [8];
  int nwr = 0, nrd = 0, busy_left = 0, viol = 0, pwlow = 0, busy_cfg = 0;
  logic we_p = 1'b1, oe_p = 1'b1, tog = 1'b0, pmode = 1'b0, pd7 = 1'b0, mdl_clr = 1'b0;
  logic [18:0] cur_a = '0;
  logic [15:0] cur_d = '0, rd_val;

  initial for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;

  always_comb begin
    if (busy_left > 0) begin
      rd_val = 16'h0;
      rd_val[6] = tog;
      rd_val[7] = pmode ? !pd7 : 1'b0;
    end else rd_val = mem[fl_addr[3:0]];
  end
  assign fl_dq_in = (!fl_ce_n && !fl_oe_n) ? rd_val : 16'h0;

  always @(negedge clk) begin
    if (mdl_clr) begin
      nwr = 0; nrd = 0; busy_left = 0; viol = 0; tog = 1'b0;
    end else if (rst_n) begin
      if ((!fl_we_n || !fl_oe_n) && fl_ce_n) viol++;
      if (!fl_we_n && !fl_oe_n) viol++;
      if (!fl_we_n) begin
        if (we_p) begin cur_a = fl_addr; cur_d = fl_dq_out; pwlow = 1; end
        else begin
          pwlow++;
          if (fl_addr != cur_a || fl_dq_out != cur_d) viol++;
        end
      end else if (!we_p) begin
        if (!fl_dq_oe || fl_dq_out != cur_d || pwlow != PULSE) viol++;
        if (nwr < 8) begin log_a[nwr] = cur_a; log_d[nwr] = cur_d; end
        nwr++;
        if (nwr == 4 && log_d[2] == 16'h00A0) begin
          mem[cur_a[3:0]] = mem[cur_a[3:0]] & cur_d;
          pmode = 1'b1; pd7 = cur_d[7]; busy_left = busy_cfg; tog = 1'b0;
        end else if (nwr == 6) begin
          for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;
          pmode = 1'b0; busy_left = busy_cfg; tog = 1'b0;
        end
      end
      if (fl_oe_n && !oe_p) begin
        nrd++;
        if (busy_left > 0) begin busy_left--; tog = !tog; end
      end
    end
    we_p = fl_we_n;
    oe_p = fl_oe_n;
  end

  // ---------------- expected command sequences (R2, R3) ----------------
  function automatic logic [18:0] ex_a(input logic [2:0] op, input int i, input logic [18:0] a);
    if (i == 1 || i == 4) return 19'h02AAA;
    if (op == 3'd1 && i == 3) return a;
    if ((op == 3'd2 || op == 3'd3) && i == 5) return a;
    return 19'h05555;
  endfunction

  function automatic logic [15:0] ex_d(input logic [2:0] op, input int i, input logic [15:0] d);
    case (i)
      0: return 16'h00AA;
      1: return 16'h0055;
      2: return (op == 3'd1) ? 16'h00A0 : 16'h0080;
      3: return (op == 3'd1) ? d : 16'h00AA;
      4: return 16'h0055;
      default: return (op == 3'd2) ? 16'h0030 : (op == 3'd3) ? 16'h0050 : 16'h0010;
    endcase
  endfunction

  // ---------------- request driver ----------------
  logic got_done, got_err;
  logic [15:0] got_rd;

  task automatic model_clear(input int busy);
    busy_cfg = busy;
    mdl_clr = 1'b1;
    @(negedge clk);
    #1 mdl_clr = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic tg, input logic [18:0] a,
                        input logic [15:0] d, input int busy);
    int cyc;
    model_clear(busy);
    req_op = op; req_addr = a; req_data = d; poll_toggle = tg; req_valid = 1'b1;
    cyc = 0;
    while (!req_ready && cyc < 4000) begin @(negedge clk); cyc++; end
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!(done || err) && cyc < 4000) begin @(negedge clk); cyc++; end
    chk(cyc < 4000, "R9 watchdog: request never completed", cyc, 0);
    got_done = done; got_err = err; got_rd = rd_data;
    chk(!req_ready, "R9 ready low during completion pulse", req_ready, 0);
    @(negedge clk);
    chk(!done && !err && req_ready, "R11/R9 pulse is one cycle, ready returns",
        {done, err, req_ready}, 3'b001);
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic        tg;
    logic [18:0] a;
    logic [15:0] d;
    logic [7:0]  busy;
    logic        xerr;
    logic [15:0] xrd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 1'b0, 19'h00000, 16'h0000, 8'd6,   1'b0, 16'h0000},
    '{3'd1, 1'b0, 19'h00003, 16'h1234, 8'd3,   1'b0, 16'h0000},
    '{3'd0, 1'b0, 19'h00003, 16'h0000, 8'd0,   1'b0, 16'h1234},
    '{3'd1, 1'b1, 19'h00005, 16'h00C3, 8'd4,   1'b0, 16'h0000},
    '{3'd1, 1'b0, 19'h00006, 16'h0085, 8'd0,   1'b0, 16'h0000},
    '{3'd0, 1'b1, 19'h00005, 16'h0000, 8'd0,   1'b0, 16'h00C3},
    '{3'd2, 1'b1, 19'h12800, 16'h0000, 8'd5,   1'b0, 16'h0000},
    '{3'd3, 1'b0, 19'h48000, 16'h0000, 8'd9,   1'b0, 16'h0000},
    '{3'd0, 1'b0, 19'h00006, 16'h0000, 8'd0,   1'b0, 16'hFFFF},
    '{3'd2, 1'b1, 19'h01000, 16'h0000, 8'd250, 1'b1, 16'h0000},
    '{3'd1, 1'b0, 19'h00009, 16'h0017, 8'd40,  1'b0, 16'h0000},
    '{3'd0, 1'b0, 19'h00009, 16'h0000, 8'd0,   1'b0, 16'h0017}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int bad_rdy, extra;
    // R1 during and after reset
    repeat (3) @(negedge clk);
    chk(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !done && !err,
        "R1 state while in reset", {req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, done, err}, 7'b1111000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !done && !err,
        "R1 state after reset", {req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, done, err}, 7'b1111000);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      run_op(t.op, t.tg, t.a, t.d, int'(t.busy));
      chk(got_err == t.xerr && got_done == !t.xerr, $sformatf("R8 outcome row %0d", v),
          {got_done, got_err}, {!t.xerr, t.xerr});
      if (t.op == 3'd0) begin
        chk(got_rd == t.xrd, $sformatf("R5 read data row %0d", v), got_rd, t.xrd);
        chk(nwr == 0 && nrd == 1, $sformatf("R5 one read, no write row %0d", v), {nwr, nrd}, 1);
      end else begin
        int len;
        bit seq_ok;
        len = (t.op == 3'd1) ? 4 : 6;
        chk(nwr == len, $sformatf("R2/R3 write count row %0d", v), nwr, len);
        seq_ok = 1'b1;
        for (int i = 0; i < len && i < 8; i++)
          if (log_a[i] != ex_a(t.op, i, t.a) || log_d[i] != ex_d(t.op, i, t.d)) seq_ok = 1'b0;
        chk(seq_ok, $sformatf("R2/R3 write sequence row %0d", v), log_d[len-1], ex_d(t.op, len-1, t.d));
        chk(viol == 0, $sformatf("R4 bus timing row %0d", v), viol, 0);
        if (!t.xerr && !t.tg)
          chk(nrd == int'(t.busy) + 1, $sformatf("R6 status reads row %0d", v), nrd, int'(t.busy) + 1);
        if (!t.xerr && t.tg)
          chk(nrd >= int'(t.busy) + 1 && nrd <= int'(t.busy) + 2,
              $sformatf("R7 toggle reads row %0d", v), nrd, int'(t.busy) + 2);
        if (t.xerr)
          chk(nrd < int'(t.busy), $sformatf("R8 gave up while busy row %0d", v), nrd, int'(t.busy));
      end
    end

    // R10: unsupported opcode
    run_op(3'd6, 1'b0, 19'h00001, 16'h0000, 0);
    chk(got_err && !got_done, "R10 err for op 6", {got_done, got_err}, 2'b01);
    chk(nwr == 0 && nrd == 0, "R10 no bus cycles", {nwr, nrd}, 0);

    // R9: back-pressure, second request held during a program
    model_clear(5);
    req_op = 3'd1; req_addr = 19'h0000A; req_data = 16'h0042; poll_toggle = 1'b0;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_op = 3'd0;                     // keep a read request valid while busy
    bad_rdy = 0;
    for (int c = 0; c < 4000 && !done && !err; c++) begin
      if (req_ready) bad_rdy++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(done && bad_rdy == 0, "R9 ready held low while busy", bad_rdy, 0);
    extra = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (done || err) extra++;
    end
    chk(extra == 0, "R9 no extra completion from held request", extra, 0);
    chk(nwr == 4 && nrd == 6, "R9 held request made no bus cycle", {nwr, nrd}, {32'd4, 32'd6});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule